// File: doc/BRIEF.md
# Supervisor Event-Return Frame Validator

This block runs the privileged return from an event handler back to ring-0 code. On a start pulse it first checks that the return feature is switched on and that the caller runs at privilege level zero. If either test fails it reports an invalid-opcode fault without touching memory. Otherwise it steps past the error-code slot and fetches a five-word return frame through a 64-bit read port. The frame holds the return IP, the code-selector image, the flags image, the new stack pointer and the stack-selector image.

The fetched words are checked against the current selectors, a set of reserved-bit masks and a canonical-address rule. When shadow stacks are on, a separate shadow-stack unit is then started through a start/done handshake. Only when every test has passed are the new IP, flags, stack pointer and stack level committed together in one cycle, along with the decoded side effects. These are interrupt-shadow blocking, a pending single-step, NMI unblocking and the branch-tracker set. Any failure gives a single fault pulse with a cause code, and the committed outputs stay unchanged.

The control inputs (feature enable, privilege, selectors, level, stack pointer, enables) are expected to stay stable from start until the outcome pulse.

Top module: `evret_seq`

## Requirements
- R1: With `feat_en`=0 or `priv_lvl`≠0, a start produces `fault_valid` with `fault_code`=1 (invalid opcode) on the next cycle, and no read is issued.
- R2: Otherwise the block reads five words at `cur_sp`+8, +16, +24, +32, +40, in the order return IP, CS image, flags image, new SP, SS image. `rd_req` and `rd_addr` are held until `rd_valid` is seen.
- R3: A return IP whose bits 63 down to VA_BITS-1 (48 by default, so 63:47) are not all equal gives `fault_code`=2 (general protection).
- R4: `fault_code`=2 is also raised when the CS image AND FFFFFFFF_FFF8FFFF differs from the zero-extended current CS selector. The same holds when the flags image AND FFFFFFFF_FFC2802A differs from 2. It also holds when SS image bits 31:0 AND FFF8FFFF differ from the current SS selector. SS image bits 63:32 have no effect.
- R5: The committed level `new_lvl` is the minimum of `cur_lvl` and CS image bits 17:16.
- R6: At commit, `set_int_shadow` = SS bit 16 AND new flags bit 9 AND NOT `int_shadow_active`. `pend_step` = SS bit 17 AND new flags bit 8. `nmi_unblock` = SS bit 18.
- R7: At commit, `set_tracker` = `track_en` AND NOT `track_suppress` AND CS image bit 18.
- R8: With `shstk_en`=1 and a valid frame, `ss_start` pulses for one cycle and the block waits for `ss_done`. `ss_ok`=0 then gives `fault_code`=3. On a frame fault the shadow unit is not started.
- R9: Each accepted start ends in exactly one one-cycle pulse of either `commit_valid` or `fault_valid`. On commit, `new_ip`/`new_flags`/`new_sp` equal the frame words. On a fault, all committed outputs keep their previous values.
- R10: `busy` is high from an accepted start until the outcome pulse, and a start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a return sequence |
| busy | output | 1 | Sequence in progress |
| feat_en | input | 1 | Event-return feature enabled |
| priv_lvl | input | 2 | Current privilege level |
| cur_cs_sel | input | 16 | Current code selector |
| cur_ss_sel | input | 16 | Current stack selector |
| cur_lvl | input | 2 | Current stack level |
| cur_sp | input | 64 | Current stack pointer |
| shstk_en | input | 1 | Supervisor shadow stacks enabled |
| track_en | input | 1 | Indirect-branch tracking enabled |
| track_suppress | input | 1 | Branch tracking suppressed |
| int_shadow_active | input | 1 | Interrupt shadow already in effect |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 64 | Memory read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Read data |
| ss_start | output | 1 | Start the shadow-stack unit |
| ss_done | input | 1 | Shadow-stack unit finished |
| ss_ok | input | 1 | Shadow-stack checks passed |
| commit_valid | output | 1 | One-cycle commit strobe |
| new_ip | output | 64 | Committed instruction pointer |
| new_flags | output | 64 | Committed flags |
| new_sp | output | 64 | Committed stack pointer |
| new_lvl | output | 2 | Committed stack level |
| set_tracker | output | 1 | Set branch-tracker state |
| set_int_shadow | output | 1 | Establish interrupt shadow |
| pend_step | output | 1 | Pend single-step debug event |
| nmi_unblock | output | 1 | Unblock NMIs |
| fault_valid | output | 1 | One-cycle fault strobe |
| fault_code | output | 2 | 1 invalid opcode, 2 general protection, 3 shadow-stack |

## Verification
All privilege/enable pairs tell the early invalid-opcode path apart from a normal fetch. Single-bit flips are applied across every bit of the CS, flags and SS images, which separates masked bits from free ones and shows that SS bits 63:32 are ignored. Return IPs at and just past the canonical edges, along with single flips of the upper bits, separate good addresses from bad ones. Full sweeps of level pairs, side-bit combinations, tracker enables and shadow-unit outcomes (under zero-wait and stalled memory) separate the commit values from the fault paths.

// File: rtl/evret_pkg.sv
// Package: shared constants and types for the event-return sequencer.
// Assumes a 64-bit data path and a five-word frame.
package evret_pkg;
    localparam int XLEN    = 64;
    localparam int NWORDS  = 5;
    localparam int SLOT_IP = 0;
    localparam int SLOT_CS = 1;
    localparam int SLOT_FL = 2;
    localparam int SLOT_SP = 3;
    localparam int SLOT_SS = 4;

    localparam logic [63:0] CS_KEEP_MASK = 64'hFFFF_FFFF_FFF8_FFFF;
    localparam logic [63:0] FL_KEEP_MASK = 64'hFFFF_FFFF_FFC2_802A;
    localparam logic [31:0] SS_KEEP_MASK = 32'hFFF8_FFFF;

    typedef logic [NWORDS-1:0][XLEN-1:0] frame_t;

    typedef enum logic [1:0] {
        F_NONE = 2'd0,
        F_UD   = 2'd1,
        F_GP   = 2'd2,
        F_CP   = 2'd3
    } fault_e;
endpackage

// File: rtl/evret_canon.sv
// Module: canonical-address test. An address is canonical when every bit
// above the top implemented bit equals that bit. Assumes VA_BITS < 64.
module evret_canon #(
    parameter int VA_BITS = 48
) (
    input  logic [63:0] addr,
    output logic        canon_ok
);
    localparam int TOP = VA_BITS - 1;

    // Upper slice must be all ones or all zeros.
    always_comb begin
        canon_ok = (&addr[63:TOP]) | ~(|addr[63:TOP]);
    end
endmodule

// File: rtl/evret_fetch.sv
// Module: frame fetcher. On go, reads NWORDS consecutive words starting at
// base+8 with one request outstanding; holds address until data arrives.
module evret_fetch
    import evret_pkg::*;
#(
    parameter int N = NWORDS
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [63:0] base_sp,
    output logic        rd_req,
    output logic [63:0] rd_addr,
    input  logic        rd_valid,
    input  logic [63:0] rd_data,
    output frame_t      words,
    output logic        done
);
    localparam int          CW   = $clog2(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic          cap;

    assign rd_req = active;
    assign cap    = active & rd_valid;

    // Sequence control: address, word index and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            rd_addr <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active  <= 1'b1;
                cnt     <= '0;
                rd_addr <= base_sp + 64'd8;
            end else if (cap) begin
                rd_addr <= rd_addr + 64'd8;
                cnt     <= cnt + 1'b1;
                if (cnt == LAST) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // One capture register per frame slot.
    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[i] <= '0;
            end else if (cap && cnt == CW'(i)) begin
                words[i] <= rd_data;
            end
        end
    end

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && cnt != LAST) |=> (rd_addr == $past(rd_addr) + 64'd8));
    p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: rtl/evret_check.sv
// Module: combinational frame checker and side-bit decoder.
// Assumes words hold a complete fetched frame when evaluated.
module evret_check
    import evret_pkg::*;
#(
    parameter int VA_BITS = 48
) (
    input  frame_t      words,
    input  logic [15:0] cur_cs_sel,
    input  logic [15:0] cur_ss_sel,
    input  logic [1:0]  cur_lvl,
    input  logic        track_en,
    input  logic        track_suppress,
    input  logic        int_shadow_active,
    output logic        frame_ok,
    output logic [1:0]  lvl_out,
    output logic        tracker_out,
    output logic        shadow_out,
    output logic        step_out,
    output logic        nmi_out
);
    logic [63:0] ip_w, cs_w, fl_w, ss_w;
    logic        ip_canon;
    logic        cs_ok, fl_ok, ss_ok_w;
    logic [1:0]  cs_lvl;
    logic        unused_ss_hi;

    assign ip_w = words[SLOT_IP];
    assign cs_w = words[SLOT_CS];
    assign fl_w = words[SLOT_FL];
    assign ss_w = words[SLOT_SS];
    assign unused_ss_hi = ^{ss_w[63:32], words[SLOT_SP]};

    evret_canon #(.VA_BITS(VA_BITS)) u_ip_canon (
        .addr     (ip_w),
        .canon_ok (ip_canon)
    );

    // Mask comparisons of the selector and flags images.
    always_comb begin
        cs_ok    = (cs_w & CS_KEEP_MASK) == {48'd0, cur_cs_sel};
        fl_ok    = (fl_w & FL_KEEP_MASK) == 64'd2;
        ss_ok_w  = (ss_w[31:0] & SS_KEEP_MASK) == {16'd0, cur_ss_sel};
        frame_ok = ip_canon & cs_ok & fl_ok & ss_ok_w;
    end

    // Level never rises: take the smaller of current and popped level.
    always_comb begin
        cs_lvl  = cs_w[17:16];
        lvl_out = (cs_lvl < cur_lvl) ? cs_lvl : cur_lvl;
    end

    // Side-bit decode gated by the new flags and current state.
    always_comb begin
        tracker_out = track_en & ~track_suppress & cs_w[18];
        shadow_out  = ss_w[16] & fl_w[9] & ~int_shadow_active;
        step_out    = ss_w[17] & fl_w[8];
        nmi_out     = ss_w[18];
    end
endmodule

// File: rtl/evret_seq.sv
// Module: top-level event-return sequencer. Gates entry on feature enable and
// privilege, fetches the frame, checks it, optionally waits on the shadow-stack
// unit, then commits atomically or reports one fault. Assumes control inputs
// stay stable from start to the outcome pulse.
module evret_seq
    import evret_pkg::*;
#(
    parameter int VA_BITS = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    input  logic        feat_en,
    input  logic [1:0]  priv_lvl,
    input  logic [15:0] cur_cs_sel,
    input  logic [15:0] cur_ss_sel,
    input  logic [1:0]  cur_lvl,
    input  logic [63:0] cur_sp,
    input  logic        shstk_en,
    input  logic        track_en,
    input  logic        track_suppress,
    input  logic        int_shadow_active,
    output logic        rd_req,
    output logic [63:0] rd_addr,
    input  logic        rd_valid,
    input  logic [63:0] rd_data,
    output logic        ss_start,
    input  logic        ss_done,
    input  logic        ss_ok,
    output logic        commit_valid,
    output logic [63:0] new_ip,
    output logic [63:0] new_flags,
    output logic [63:0] new_sp,
    output logic [1:0]  new_lvl,
    output logic        set_tracker,
    output logic        set_int_shadow,
    output logic        pend_step,
    output logic        nmi_unblock,
    output logic        fault_valid,
    output logic [1:0]  fault_code
);
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK, S_SHADOW} state_e;

    state_e  state;
    logic    fetch_go;
    logic    fetch_done;
    frame_t  words;
    logic    frame_ok;
    logic [1:0] lvl_c;
    logic    trk_c, shd_c, stp_c, nmi_c;
    logic    entry_bad;
    logic    do_commit;

    assign busy      = (state != S_IDLE);
    assign entry_bad = ~feat_en | (priv_lvl != 2'd0);
    assign fetch_go  = (state == S_IDLE) & start & ~entry_bad;

    evret_fetch #(.N(NWORDS)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (fetch_go),
        .base_sp  (cur_sp),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .words    (words),
        .done     (fetch_done)
    );

    evret_check #(.VA_BITS(VA_BITS)) u_check (
        .words             (words),
        .cur_cs_sel        (cur_cs_sel),
        .cur_ss_sel        (cur_ss_sel),
        .cur_lvl           (cur_lvl),
        .track_en          (track_en),
        .track_suppress    (track_suppress),
        .int_shadow_active (int_shadow_active),
        .frame_ok          (frame_ok),
        .lvl_out           (lvl_c),
        .tracker_out       (trk_c),
        .shadow_out        (shd_c),
        .step_out          (stp_c),
        .nmi_out           (nmi_c)
    );

    // Commit fires from CHECK without shadow stacks, or from SHADOW on success.
    always_comb begin
        do_commit = ((state == S_CHECK) & frame_ok & ~shstk_en) |
                    ((state == S_SHADOW) & ss_done & ss_ok);
    end

    // Sequencer state, handshake strobe and fault reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            ss_start    <= 1'b0;
            fault_valid <= 1'b0;
            fault_code  <= F_NONE;
        end else begin
            ss_start    <= 1'b0;
            fault_valid <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start && entry_bad) begin
                        fault_valid <= 1'b1;
                        fault_code  <= F_UD;
                    end else if (start) begin
                        state <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (fetch_done) state <= S_CHECK;
                end
                S_CHECK: begin
                    if (!frame_ok) begin
                        fault_valid <= 1'b1;
                        fault_code  <= F_GP;
                        state       <= S_IDLE;
                    end else if (shstk_en) begin
                        ss_start <= 1'b1;
                        state    <= S_SHADOW;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                S_SHADOW: begin
                    if (ss_done) begin
                        state <= S_IDLE;
                        if (!ss_ok) begin
                            fault_valid <= 1'b1;
                            fault_code  <= F_CP;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Architectural outputs: written only on a successful commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_valid   <= 1'b0;
            new_ip         <= '0;
            new_flags      <= '0;
            new_sp         <= '0;
            new_lvl        <= '0;
            set_tracker    <= 1'b0;
            set_int_shadow <= 1'b0;
            pend_step      <= 1'b0;
            nmi_unblock    <= 1'b0;
        end else begin
            commit_valid <= do_commit;
            if (do_commit) begin
                new_ip         <= words[SLOT_IP];
                new_flags      <= words[SLOT_FL];
                new_sp         <= words[SLOT_SP];
                new_lvl        <= lvl_c;
                set_tracker    <= trk_c;
                set_int_shadow <= shd_c;
                pend_step      <= stp_c;
                nmi_unblock    <= nmi_c;
            end
        end
    end

    p_ud_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && (!feat_en || priv_lvl != 2'd0))
        |=> (fault_valid && fault_code == F_UD && !rd_req));
    p_lvl_no_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (new_lvl <= cur_lvl));
    p_ss_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start |=> !ss_start);
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_valid && fault_valid));
    p_hold_on_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> ($stable(new_ip) && $stable(new_sp) && $stable(new_flags)));
    p_idle_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);
endmodule

// File: tb/evret_seq_bench.sv
// Bench: sweeps the sequencer with a bench memory and shadow-unit model.
module evret_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy;
    logic        feat_en = 1'b1;
    logic [1:0]  priv_lvl = 2'd0;
    logic [15:0] cur_cs_sel = 16'h0010;
    logic [15:0] cur_ss_sel = 16'h0018;
    logic [1:0]  cur_lvl = 2'd3;
    logic [63:0] cur_sp = 64'h0000_0000_0000_1000;
    logic        shstk_en = 1'b0;
    logic        track_en = 1'b0;
    logic        track_suppress = 1'b0;
    logic        int_shadow_active = 1'b0;
    logic        rd_req;
    logic [63:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic        ss_start;
    logic        ss_done = 1'b0;
    logic        ss_ok = 1'b1;
    logic        commit_valid;
    logic [63:0] new_ip, new_flags, new_sp;
    logic [1:0]  new_lvl;
    logic        set_tracker, set_int_shadow, pend_step, nmi_unblock;
    logic        fault_valid;
    logic [1:0]  fault_code;

    evret_seq u_evret_seq (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic [63:0] frm [5];
    logic [63:0] rlog [8];
    int nreads = 0;
    int sh_starts = 0;
    int sh_cnt = 0;
    logic mem_lat = 1'b0;
    logic stall_tog = 1'b0;
    logic ss_ok_cfg = 1'b1;

    localparam logic [63:0] BASE_IP = 64'h0000_0000_0040_1000;
    localparam logic [63:0] BASE_SP = 64'h0000_7FFF_FFF0_0000;
    localparam logic [63:0] BASE_FL = 64'h0000_0000_0000_0202;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bench memory model, optional stall every other cycle.
    always @(negedge clk) begin
        if (rd_req && (!mem_lat || stall_tog)) begin
            logic [63:0] idx;
            idx = (rd_addr - cur_sp - 64'd8) >> 3;
            rd_valid = 1'b1;
            rd_data  = (idx < 5) ? frm[idx[2:0]] : 64'hDEAD_BEEF_DEAD_BEEF;
            if (nreads < 8) rlog[nreads] = rd_addr;
            nreads++;
        end else begin
            rd_valid = 1'b0;
        end
        stall_tog = ~stall_tog;
    end

    // Shadow-stack unit model: answers two cycles after a start.
    always @(negedge clk) begin
        ss_done = 1'b0;
        if (ss_start) begin
            sh_starts++;
            sh_cnt = 2;
        end else if (sh_cnt > 0) begin
            sh_cnt--;
            if (sh_cnt == 0) begin
                ss_done = 1'b1;
                ss_ok   = ss_ok_cfg;
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    function automatic logic canon48(input logic [63:0] a);
        return (&a[63:47]) | ~(|a[63:47]);
    endfunction

    // Run one return with the current config and check every observable.
    task automatic run_frame(input logic [63:0] w0, w1, w2, w3, w4);
        logic [63:0] pip, pfl, psp;
        logic [1:0]  plv, ecode, elvl, cslv;
        logic        saw_c, saw_f;
        logic [1:0]  got_code;
        int          n;
        frm[0] = w0; frm[1] = w1; frm[2] = w2; frm[3] = w3; frm[4] = w4;
        pip = new_ip; pfl = new_flags; psp = new_sp; plv = new_lvl;
        nreads = 0; sh_starts = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!(commit_valid || fault_valid) && n < 300) begin
            @(negedge clk);
            n++;
        end
        saw_c = commit_valid; saw_f = fault_valid; got_code = fault_code;
        if (!feat_en || priv_lvl != 2'd0) ecode = 2'd1;
        else if (!canon48(w0) ||
                 (w1 & 64'hFFFF_FFFF_FFF8_FFFF) != {48'd0, cur_cs_sel} ||
                 (w2 & 64'hFFFF_FFFF_FFC2_802A) != 64'd2 ||
                 (w4[31:0] & 32'hFFF8_FFFF) != {16'd0, cur_ss_sel}) ecode = 2'd2;
        else if (shstk_en && !ss_ok_cfg) ecode = 2'd3;
        else ecode = 2'd0;
        cslv = w1[17:16];
        elvl = (cslv < cur_lvl) ? cslv : cur_lvl;
        chk("R9 one outcome", {62'd0, saw_c, saw_f}, (ecode == 0) ? 64'd2 : 64'd1);
        if (ecode != 0) begin
            chk("R1/R3/R4/R8 fault code", {62'd0, got_code}, {62'd0, ecode});
            chk("R9 ip held", new_ip, pip);
            chk("R9 sp held", new_sp, psp);
            chk("R9 flags/lvl held", {new_flags[61:0], new_lvl}, {pfl[61:0], plv});
            if (ecode == 2'd1) chk("R1 no read", nreads, 0);
            if (ecode == 2'd2) chk("R8 no shadow start on frame fault", sh_starts, 0);
        end else begin
            chk("R9 ip", new_ip, w0);
            chk("R9 flags", new_flags, w2);
            chk("R9 sp", new_sp, w3);
            chk("R5 level", {62'd0, new_lvl}, {62'd0, elvl});
            chk("R6 int shadow", {63'd0, set_int_shadow},
                {63'd0, w4[16] & w2[9] & ~int_shadow_active});
            chk("R6 pend step", {63'd0, pend_step}, {63'd0, w4[17] & w2[8]});
            chk("R6 nmi unblock", {63'd0, nmi_unblock}, {63'd0, w4[18]});
            chk("R7 tracker", {63'd0, set_tracker},
                {63'd0, track_en & ~track_suppress & w1[18]});
            chk("R8 shadow starts", sh_starts, shstk_en ? 1 : 0);
            chk("R2 read count", nreads, 5);
        end
        @(negedge clk);
        chk("R10 idle after outcome", {63'd0, busy}, 64'd0);
    endtask

    function automatic logic [63:0] cs_img();
        return {48'd0, cur_cs_sel};
    endfunction
    function automatic logic [63:0] ss_img();
        return {48'd0, cur_ss_sel};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset commit", {63'd0, commit_valid}, 64'd0);
        chk("R9 reset fault", {63'd0, fault_valid}, 64'd0);
        chk("R10 reset busy", {63'd0, busy}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every privilege/enable pair.
        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 2; f++) begin
                priv_lvl = p[1:0];
                feat_en  = f[0];
                run_frame(BASE_IP, cs_img(), BASE_FL, BASE_SP, ss_img());
            end
        end
        priv_lvl = 2'd0; feat_en = 1'b1;

        // R2: address order, zero-wait and stalled memory.
        for (int l = 0; l < 2; l++) begin
            mem_lat = l[0];
            run_frame(BASE_IP, cs_img(), BASE_FL, BASE_SP, ss_img());
            for (int k = 0; k < 5; k++)
                chk("R2 address order", rlog[k], cur_sp + 64'd8 * (k + 1));
        end

        // R10: start while busy is ignored (one outcome, five reads).
        mem_lat = 1'b1;
        frm[0] = BASE_IP; frm[1] = cs_img(); frm[2] = BASE_FL; frm[3] = BASE_SP; frm[4] = ss_img();
        nreads = 0;
        start = 1'b1;
        @(negedge clk);
        chk("R10 busy after start", {63'd0, busy}, 64'd1);
        repeat (2) @(negedge clk);
        start = 1'b0;
        begin
            int n;
            n = 0;
            while (!commit_valid && n < 100) begin @(negedge clk); n++; end
            chk("R10 commit after ignored start", {63'd0, commit_valid}, 64'd1);
            @(negedge clk);
            chk("R10 no second sequence", {63'd0, busy}, 64'd0);
            chk("R10 read count", nreads, 5);
        end
        mem_lat = 1'b0;

        // R3: canonical edges and upper-bit flips.
        run_frame(64'h0000_7FFF_FFFF_FFFF, cs_img(), BASE_FL, BASE_SP, ss_img());
        run_frame(64'h0000_8000_0000_0000, cs_img(), BASE_FL, BASE_SP, ss_img());
        run_frame(64'hFFFF_8000_0000_0000, cs_img(), BASE_FL, BASE_SP, ss_img());
        run_frame(64'hFFFF_7FFF_FFFF_FFFF, cs_img(), BASE_FL, BASE_SP, ss_img());
        for (int b = 47; b < 64; b++)
            run_frame(BASE_IP ^ (64'd1 << b), cs_img(), BASE_FL, BASE_SP, ss_img());

        // R4: single-bit flips across CS, flags and SS images.
        for (int b = 0; b < 64; b++) begin
            run_frame(BASE_IP, cs_img() ^ (64'd1 << b), BASE_FL, BASE_SP, ss_img());
            run_frame(BASE_IP, cs_img(), BASE_FL ^ (64'd1 << b), BASE_SP, ss_img());
            run_frame(BASE_IP, cs_img(), BASE_FL, BASE_SP, ss_img() ^ (64'd1 << b));
        end

        // R5: every current/popped level pair.
        for (int c = 0; c < 4; c++) begin
            for (int q = 0; q < 4; q++) begin
                cur_lvl = c[1:0];
                run_frame(BASE_IP, cs_img() | (64'(q) << 16), BASE_FL, BASE_SP, ss_img());
            end
        end
        cur_lvl = 2'd3;

        // R6: SS side bits x IF/TF x shadow already active.
        for (int v = 0; v < 64; v++) begin
            logic [5:0] s;
            s = v[5:0];
            int_shadow_active = s[5];
            run_frame(BASE_IP, cs_img(),
                      (64'd2 | (64'(s[3]) << 9) | (64'(s[4]) << 8)), BASE_SP,
                      ss_img() | (64'(s[2:0]) << 16));
        end
        int_shadow_active = 1'b0;

        // R7: tracker enables x restore bit.
        for (int v = 0; v < 8; v++) begin
            track_en = v[0]; track_suppress = v[1];
            run_frame(BASE_IP, cs_img() | (64'(v[2]) << 18), BASE_FL, BASE_SP, ss_img());
        end
        track_en = 1'b0; track_suppress = 1'b0;

        // R8: shadow unit pass, fail, and frame fault before it.
        shstk_en = 1'b1;
        ss_ok_cfg = 1'b1;
        run_frame(BASE_IP, cs_img(), BASE_FL, BASE_SP, ss_img());
        ss_ok_cfg = 1'b0;
        run_frame(BASE_IP ^ 64'h1234, cs_img(), BASE_FL, BASE_SP, ss_img());
        run_frame(BASE_IP, cs_img(), 64'd0, BASE_SP, ss_img());
        mem_lat = 1'b1;
        ss_ok_cfg = 1'b1;
        run_frame(BASE_IP + 64'h40, cs_img(), BASE_FL, BASE_SP - 64'h80, ss_img());
        shstk_en = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule